// File: doc/BRIEF.md
# Frequency-Compensated Beep Tone Generator

This block makes a square-wave beep from one tap of an internal counter. The counter runs without stopping at half the rate of the system clock. Software writes a tap-select register in which one bit chooses the counter bit that drives the tone. A separate control register turns the output on and off. Setting select bit 10 gives a tone at 1/2^12 of the system clock.

When the power-saving logic slows the system clock, the counter slows with it. The block reads a frequency code and moves its tap toward lower counter bits by the same factor, so the audible pitch stays the same. The tap moves down one position for the half-rate clock and five positions for the 1/32 clock. It never goes below bit 0.

The simulation clock keeps a fixed period. Because of this, the requirements state the output period in cycles of `clk` for each frequency code.

Top module: `beep_tone_gen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `beep_o` is 0. Reset clears both the enable bit and the tap-select field.
- R2: A write with `wr_addr`=0 loads the enable bit from `wr_data[0]`. Bits 7:1 of that write have no effect: writing 0xFE leaves the output low.
- R3: While the enable bit is 0, `beep_o` stays 0.
- R4: With frequency code 2'b00 (full rate), a lowest set select bit at position p gives a period of 2^(p+2) clock cycles on `beep_o`, high for exactly half of it.
- R5: With frequency code 2'b01 (half rate), the tap is p-1, so the period is 2^(p+1) cycles with a 50% duty cycle.
- R6: With frequency code 2'b10 (1/32 rate), the tap is p-5, so the period is 2^(p-3) cycles. Code 2'b11 behaves as full rate.
- R7: A write with `wr_addr`=1 loads the select field from `wr_data[18:10]`. Every other bit of that write is ignored: extra low bits do not change the tone, and a value with no bit inside 18:10 gives a silent output.
- R8: When more than one select bit is set, the lowest set bit sets the tone.
- R9: While the select field is all zero, `beep_o` stays 0 even when enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control register, 1 = tap-select register |
| wr_data | input | 32 | Write data |
| freq_code | input | 2 | Current system clock rate: 00 full, 01 half, 10 1/32, 11 full |
| beep_o | output | 1 | Registered square-wave beep |

## Verification
The assertions check four things on every cycle:
- the reset value of the output;
- that each register write lands in the enable bit and the select field;
- that the output is silent while the block is disabled;
- that the output is silent while the select field is empty.

The pitch itself can only be shown by the bench. It measures whole periods and high times of the output for each frequency code, for several combinations of select bits, and for values that carry junk outside the select field. The bench also confirms that the lowest set bit wins and that reserved control bits leave the output silent.

// File: rtl/beep_pkg.sv
package beep_pkg;

  typedef enum logic [1:0] {
    RATE_FULL  = 2'b00,
    RATE_HALF  = 2'b01,
    RATE_DIV32 = 2'b10
  } rate_code_e;

  localparam int unsigned SHIFT_HALF  = 1;
  localparam int unsigned SHIFT_DIV32 = 5;

  // Tap displacement for a given clock rate code
  function automatic int unsigned rate_shift(logic [1:0] code);
    case (code)
      RATE_HALF:  return SHIFT_HALF;
      RATE_DIV32: return SHIFT_DIV32;
      default:    return 0;
    endcase
  endfunction

endpackage

// File: rtl/beep_regs.sv
module beep_regs #(
  parameter int DATA_W = 32,
  parameter int SEL_LO = 10,
  parameter int SEL_HI = 18,
  localparam int FIELD_W = SEL_HI - SEL_LO + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  output logic               en_q,
  output logic [FIELD_W-1:0] sel_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      sel_q <= '0;
    end else if (wr_en) begin
      if (wr_addr) sel_q <= wr_data[SEL_HI:SEL_LO];
      else         en_q  <= wr_data[0];
    end
  end

endmodule

// File: rtl/beep_free_counter.sv
module beep_free_counter #(
  parameter int CNT_W = 19
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt
);

  logic phase_q;

  // phase_q halves the rate: the count moves on every second clock
  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= 1'b0;
      cnt     <= '0;
    end else begin
      phase_q <= ~phase_q;
      if (phase_q) cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/beep_tap_select.sv
module beep_tap_select
  import beep_pkg::*;
#(
  parameter int SEL_LO  = 10,
  parameter int FIELD_W = 9,
  parameter int CNT_W   = 19,
  parameter int IDX_W   = 5
) (
  input  logic [FIELD_W-1:0] sel_field,
  input  logic [1:0]         rate_code,
  output logic [IDX_W-1:0]   tap_idx,
  output logic               tap_valid
);

  logic [FIELD_W-1:0] lowest_hot;

  // Isolate the lowest set bit of the select field
  generate
    for (genvar g = 0; g < FIELD_W; g++) begin : g_low
      if (g == 0) begin : g_first
        assign lowest_hot[g] = sel_field[g];
      end else begin : g_rest
        assign lowest_hot[g] = sel_field[g] & ~(|sel_field[g-1:0]);
      end
    end
  endgenerate

  always_comb begin
    int pos;
    int tap;
    pos = 0;
    for (int i = 0; i < FIELD_W; i++) begin
      if (lowest_hot[i]) pos = SEL_LO + i;
    end
    tap = pos - int'(rate_shift(rate_code));
    if (tap < 0) tap = 0;
    if (tap > CNT_W - 1) tap = CNT_W - 1;
    tap_idx   = IDX_W'(tap);
    tap_valid = |sel_field;
  end

endmodule

// File: rtl/beep_tone_gen.sv
module beep_tone_gen #(
  parameter int DATA_W = 32,
  parameter int SEL_LO = 10,
  parameter int SEL_HI = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        freq_code,
  output logic              beep_o
);

  localparam int FIELD_W = SEL_HI - SEL_LO + 1;
  localparam int CNT_W   = SEL_HI + 1;
  localparam int IDX_W   = $clog2(CNT_W);

  logic               en_q;
  logic [FIELD_W-1:0] sel_q;
  logic [CNT_W-1:0]   cnt;
  logic [IDX_W-1:0]   tap_idx;
  logic               tap_valid;

  beep_regs #(
    .DATA_W(DATA_W), .SEL_LO(SEL_LO), .SEL_HI(SEL_HI)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .en_q(en_q), .sel_q(sel_q)
  );

  beep_free_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .cnt(cnt)
  );

  beep_tap_select #(
    .SEL_LO(SEL_LO), .FIELD_W(FIELD_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_tap (
    .sel_field(sel_q), .rate_code(freq_code),
    .tap_idx(tap_idx), .tap_valid(tap_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) beep_o <= 1'b0;
    else     beep_o <= en_q & tap_valid & cnt[tap_idx];
  end

endmodule

// File: rtl/beep_tone_gen_chk.sv
module beep_tone_gen_chk #(
  parameter int DATA_W  = 32,
  parameter int SEL_LO  = 10,
  parameter int SEL_HI  = 18,
  localparam int FIELD_W = SEL_HI - SEL_LO + 1
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic               wr_addr,
  input logic [DATA_W-1:0]  wr_data,
  input logic               beep_o,
  input logic               en_q,
  input logic [FIELD_W-1:0] sel_q
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!beep_o && !en_q && sel_q == '0));

  // R2
  enable_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_addr) |=> (en_q == $past(wr_data[0])));

  // R7
  select_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr) |=> (sel_q == $past(wr_data[SEL_HI:SEL_LO])));

  // R3
  disabled_silent_chk: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !beep_o);

  // R9
  empty_select_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_q == '0) |=> !beep_o);

endmodule

bind beep_tone_gen beep_tone_gen_chk #(
  .DATA_W(DATA_W), .SEL_LO(SEL_LO), .SEL_HI(SEL_HI)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .beep_o(beep_o), .en_q(en_q), .sel_q(sel_q)
);

// File: tb/tb_beep_tone_gen.sv
module tb_beep_tone_gen;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [31:0] wr_data = '0;
  logic [1:0]  freq_code = 2'b00;
  logic        beep_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  beep_tone_gen dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .freq_code(freq_code), .beep_o(beep_o)
  );

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // Expected period in clk cycles for lowest select bit p and rate code
  function automatic int exp_period(int p, logic [1:0] code);
    int sh;
    int t;
    sh = (code == 2'b01) ? 1 : (code == 2'b10) ? 5 : 0;
    t = p - sh;
    if (t < 0) t = 0;
    return 1 << (t + 2);
  endfunction

  task automatic write_reg(bit a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic wait_rise(output bit ok);
    bit prev;
    prev = beep_o;
    ok = 1'b0;
    for (int n = 0; n < 20000; n++) begin
      @(negedge clk);
      if (!prev && beep_o) begin
        ok = 1'b1;
        return;
      end
      prev = beep_o;
    end
  endtask

  task automatic measure(string req, int p, logic [1:0] code);
    bit ok1, ok2, prev, done;
    int per, hi, e;
    e = exp_period(p, code);
    wait_rise(ok1);
    wait_rise(ok2);
    chk(ok1 && ok2, req, 0, 1);
    if (!(ok1 && ok2)) return;
    per = 0; hi = 1; prev = 1'b1; done = 1'b0;
    while (!done && per < 40000) begin
      @(negedge clk);
      per++;
      if (!prev && beep_o) done = 1'b1;
      else begin
        if (beep_o) hi++;
        prev = beep_o;
      end
    end
    chk(per == e, req, per, e);
    chk(hi == e / 2, req, hi, e / 2);
  endtask

  task automatic expect_low(string req, int n);
    bit seen;
    seen = 1'b0;
    repeat (n) begin
      @(negedge clk);
      if (beep_o) seen = 1'b1;
    end
    chk(!seen, req, seen, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    int unsigned r;
    r = $urandom(32'hBEE9);
    repeat (5) @(negedge clk);
    chk(beep_o == 1'b0, "R1", beep_o, 0);
    rst = 1'b0;
    expect_low("R1", 60);

    // Directed: bit 10 at each rate code
    write_reg(1'b1, 32'h0000_0400);
    write_reg(1'b0, 32'h0000_0001);
    freq_code = 2'b00; measure("R4", 10, 2'b00);
    freq_code = 2'b01; measure("R5", 10, 2'b01);
    freq_code = 2'b10; measure("R6", 10, 2'b10);
    freq_code = 2'b11; measure("R6", 10, 2'b11);

    // Enable control and reserved bits
    freq_code = 2'b10;
    write_reg(1'b0, 32'h0000_0000);
    expect_low("R3", 400);
    write_reg(1'b0, 32'h0000_00FE);
    expect_low("R2", 400);
    write_reg(1'b0, 32'h0000_0001);
    measure("R2", 10, 2'b10);

    // Select field corners
    write_reg(1'b1, 32'h0000_0408);
    measure("R7", 10, 2'b10);
    write_reg(1'b1, 32'hFFF8_0020);
    expect_low("R7", 400);
    write_reg(1'b1, 32'h0000_5000);
    measure("R8", 12, 2'b10);
    write_reg(1'b1, 32'h0000_0000);
    expect_low("R9", 400);

    // Random: lowest bit plus higher and out-of-field junk
    for (int k = 0; k < 6; k++) begin
      int p;
      logic [1:0] code;
      logic [8:0] f;
      logic [31:0] v;
      code = (($urandom & 1) != 0) ? 2'b01 : 2'b10;
      p = 10 + int'((code == 2'b01) ? ($urandom % 2) : ($urandom % 4));
      f = 9'(1 << (p - 10));
      f = f | (9'($urandom) & ~((f << 1) - 9'd1));
      v = ({23'd0, f} << 10) | ($urandom & 32'hFFF8_03FF);
      freq_code = code;
      write_reg(1'b1, v);
      measure("R8", p, code);
    end

    summary();
    $finish;
  end

endmodule